// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block decides when a small 8-bit processor core must leave its normal instruction stream and then drives the bus cycles of the entry sequence. Four sources can cause an entry: the reset pin, an edge-triggered non-maskable request, a level-triggered maskable request, and a software break that the decoder reports. Reset is handled apart from the others. Any sampled low level on the reset pin aborts whatever is running. The release of reset then starts a fixed sequence that ends by loading the program counter from the reset vector.

The other three sources are examined only when the core signals an instruction boundary. The sequencer samples the core's program counter, status byte and stack pointer at that point. It pushes the program counter and the status onto the stack page and reads the 16-bit vector for the chosen source. It then hands the core a program-counter load, a stack-pointer load and a pulse that sets the interrupt-disable flag. A ready input stretches any interrupt-sequence cycle. The core watches `busy` to hold its own pipeline while a sequence runs.

Top module: `irq_entry_sequencer`

## Requirements
- R1: While `rst_n` is sampled low, `busy` is 1, `vec_pull_n` is 1, and every other output is 0, whatever the value of `rdy`. A low `rst_n` that arrives during an interrupt sequence aborts that sequence.
- R2: The reset sequence starts at the first rising clock edge that samples `rst_n` high and lasts 7 cycles. Cycles 1 to 5 make no bus request. Cycle 6 reads address FFFC. Cycle 7 reads FFFD and asserts `pc_load` and `set_i` with `pc_value` = {byte at FFFD, byte at FFFC}. `busy` drops in the cycle after that. `rdy` has no effect on any of these cycles.
- R3: A falling edge on `nmi_n` is latched and served at a later boundary with vector FFFA (low byte) and FFFB (high byte). This includes an edge that arrives while another entry sequence is running.
- R4: Holding `nmi_n` low after an edge has been served causes no further entry. Only a new high-to-low transition does.
- R5: A low `irq_n` causes an entry at a boundary only when `i_flag` is 0. With `i_flag` at 1 the request is ignored: `busy` stays 0 and no bus request appears.
- R6: An accepted boundary is followed by exactly five cycles, in this order. First, a write of pc[15:8] to address 0x0100+sp. Second, a write of pc[7:0] to 0x0100+(sp-1). Third, a write of the status byte to 0x0100+(sp-2). Fourth, a read of the vector low byte. Fifth, a read of the vector high byte. The fifth cycle asserts `pc_load`, `sp_load` (with `sp_value` = sp-3) and `set_i`. `busy` is 0 on the next cycle. `bus_wdata` is 0 outside the three push cycles. `pc_value` and `sp_value` are 0 outside the cycles that carry them.
- R7: The pushed status equals `status_in`, except that bit 5 is forced to 1 and bit 4 is 1 for a software break and 0 for a hardware request.
- R8: When several sources are pending at the same boundary, they are served in this order: non-maskable, then maskable, then break. A break uses vector FFFE/FFFF, the same vector as the maskable request.
- R9: `vec_pull_n` is 0 exactly in the cycles that read a vector byte, and never otherwise.
- R10: With `rdy` low, an interrupt sequence holds its current cycle. Address, read request and data stay presented. `bus_wr`, `pc_load`, `sp_load` and `set_i` are 0 while `rdy` is low. A boundary is not accepted while `rdy` is low.
- R11: Stack addresses wrap inside page 0x01. With sp = 0x01, the pushes go to 0x0101, 0x0100 and 0x01FF, and `sp_value` is 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin, active low, sampled on the clock |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered |
| irq_n | input | 1 | Maskable request, active-low level |
| brk_req | input | 1 | Decoder reports a break instruction at this boundary |
| i_flag | input | 1 | Current interrupt-disable flag |
| insn_done | input | 1 | Instruction boundary strobe |
| rdy | input | 1 | Ready; low stretches the current interrupt-sequence cycle |
| pc_in | input | 16 | Program counter to save |
| status_in | input | 8 | Status byte to save |
| sp_in | input | 8 | Stack pointer at entry |
| rd_data | input | 8 | Read data from memory, valid in the same cycle |
| busy | output | 1 | Reset or entry sequence in progress |
| bus_rd | output | 1 | Read request |
| bus_wr | output | 1 | Write strobe, qualified by rdy |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| vec_pull_n | output | 1 | Low while a vector byte is read |
| pc_load | output | 1 | Load program counter with pc_value |
| pc_value | output | 16 | Fetched vector |
| sp_load | output | 1 | Load stack pointer with sp_value |
| sp_value | output | 8 | Stack pointer after the three pushes |
| set_i | output | 1 | Set the interrupt-disable flag |

## Verification
Edges on `nmi_n` are registered. A high-to-low change therefore becomes pending at the first clock edge that samples it, and is served at the boundary strobe of the following cycle or later. An accepted boundary produces the first push in the next cycle. The vector load comes four cycles after that first push. Every stalled cycle with `rdy` low adds exactly one cycle to that count. The reset vector load comes in the seventh cycle after release.

The bench drives all inputs just after a falling clock edge and compares the full output word at the next falling edge. Each compare thus reflects exactly one rising edge of state change. Arbitration is swept over all sixteen combinations of the four request conditions, and the expected source, vector, pushed bytes and stack arithmetic are computed separately in the bench.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int SP_W   = 8;

  localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
  localparam logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA;
  localparam logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_BRK  = 2'd3
  } src_t;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_RESET  = 3'd1,
    ST_IDLE   = 3'd2,
    ST_PUSH_H = 3'd3,
    ST_PUSH_L = 3'd4,
    ST_PUSH_P = 3'd5,
    ST_VEC_L  = 3'd6,
    ST_VEC_H  = 3'd7
  } st_t;

  // Low-byte vector address for a hardware or software source.
  function automatic logic [ADDR_W-1:0] vector_of(input src_t s);
    return (s == SRC_NMI) ? VEC_NMI : VEC_IRQ;
  endfunction

  // Stack-page address of the slot 'back' bytes below the saved pointer.
  function automatic logic [ADDR_W-1:0] stack_slot(input logic [SP_W-1:0] sp,
                                                   input logic [1:0] back);
    logic [SP_W-1:0] off;
    off = sp - SP_W'(back);
    return {STACK_PAGE, off};
  endfunction

  // Status image written to the stack: bit 5 forced, bit 4 marks a break.
  function automatic logic [DATA_W-1:0] framed_status(input logic [DATA_W-1:0] p,
                                                      input logic brk);
    return {p[7:6], 1'b1, brk, p[3:0]};
  endfunction

endpackage

// File: rtl/irq_seq_nmi_latch.sv
module irq_seq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take_nmi,
  output logic nmi_pend,
  output logic nmi_fell
);

  logic nmi_prev;

  assign nmi_fell = nmi_prev & ~nmi_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= nmi_n;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_n;
      nmi_pend <= (nmi_pend & ~take_nmi) | nmi_fell;
    end
  end

  // R3: a sampled falling edge is pending on the following cycle
  a_r3_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fell |=> nmi_pend);

  // R4: without a new edge, a request that is not pending stays absent
  a_r4_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_pend && !nmi_fell) |=> !nmi_pend);

endmodule

// File: rtl/irq_seq_arbiter.sv
module irq_seq_arbiter
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic boundary_ok,
  input  logic nmi_pend,
  input  logic irq_n,
  input  logic i_flag,
  input  logic brk_req,
  output src_t grant,
  output logic take_nmi
);

  localparam int N_SRC = 3;

  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] win;

  // index 0 has the highest priority
  assign req = {brk_req, ~irq_n & ~i_flag, nmi_pend};

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_prio
      if (g == 0) begin : g_top
        assign win[g] = boundary_ok & req[g];
      end else begin : g_low
        assign win[g] = boundary_ok & req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    grant = SRC_NONE;
    if (win[0])      grant = SRC_NMI;
    else if (win[1]) grant = SRC_IRQ;
    else if (win[2]) grant = SRC_BRK;
  end

  assign take_nmi = win[0];

  // R8: at most one source wins a boundary
  a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  // R5: a masked level request alone never produces a grant
  a_r5_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (i_flag && !nmi_pend && !brk_req) |-> (grant == SRC_NONE));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int RST_CYCLES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy,
  input  logic              insn_done,
  input  src_t              grant,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              boundary_ok,
  output logic              busy,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              vec_pull_n,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              sp_load,
  output logic [SP_W-1:0]   sp_value,
  output logic              set_i
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYCLES - 1);
  localparam logic [CNT_W-1:0] RST_VLO  = CNT_W'(RST_CYCLES - 2);

  st_t               state;
  logic [CNT_W-1:0]  rcnt;
  src_t              src_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] p_q;
  logic [SP_W-1:0]   sp_q;
  logic [DATA_W-1:0] vlo_q;

  logic in_irq_seq;
  logic rst_vlo_cyc;
  logic rst_vhi_cyc;
  logic [ADDR_W-1:0] vec_q;

  assign in_irq_seq  = (state == ST_PUSH_H) || (state == ST_PUSH_L) ||
                       (state == ST_PUSH_P) || (state == ST_VEC_L) ||
                       (state == ST_VEC_H);
  assign rst_vlo_cyc = (state == ST_RESET) && (rcnt == RST_VLO);
  assign rst_vhi_cyc = (state == ST_RESET) && (rcnt == RST_LAST);
  assign boundary_ok = (state == ST_IDLE) && insn_done && rdy;
  assign vec_q       = vector_of(src_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      rcnt  <= '0;
      src_q <= SRC_NONE;
      pc_q  <= '0;
      p_q   <= '0;
      sp_q  <= '0;
      vlo_q <= '0;
    end else begin
      case (state)
        ST_HOLD: begin
          state <= ST_RESET;
          rcnt  <= '0;
        end
        ST_RESET: begin
          if (rst_vlo_cyc) vlo_q <= rd_data;
          if (rst_vhi_cyc) state <= ST_IDLE;
          else             rcnt  <= rcnt + 1'b1;
        end
        ST_IDLE: begin
          if (boundary_ok && (grant != SRC_NONE)) begin
            state <= ST_PUSH_H;
            src_q <= grant;
            pc_q  <= pc_in;
            p_q   <= status_in;
            sp_q  <= sp_in;
          end
        end
        ST_PUSH_H: if (rdy) state <= ST_PUSH_L;
        ST_PUSH_L: if (rdy) state <= ST_PUSH_P;
        ST_PUSH_P: if (rdy) state <= ST_VEC_L;
        ST_VEC_L: begin
          if (rdy) begin
            vlo_q <= rd_data;
            state <= ST_VEC_H;
          end
        end
        ST_VEC_H: if (rdy) state <= ST_IDLE;
        default:  state <= ST_HOLD;
      endcase
    end
  end

  always_comb begin
    busy       = (state != ST_IDLE);
    bus_rd     = 1'b0;
    bus_wr     = 1'b0;
    bus_addr   = '0;
    bus_wdata  = '0;
    vec_pull_n = 1'b1;
    pc_load    = 1'b0;
    pc_value   = '0;
    sp_load    = 1'b0;
    sp_value   = '0;
    set_i      = 1'b0;
    case (state)
      ST_RESET: begin
        if (rst_vlo_cyc) begin
          bus_rd     = 1'b1;
          bus_addr   = VEC_RST;
          vec_pull_n = 1'b0;
        end
        if (rst_vhi_cyc) begin
          bus_rd     = 1'b1;
          bus_addr   = VEC_RST + 16'd1;
          vec_pull_n = 1'b0;
          pc_load    = 1'b1;
          pc_value   = {rd_data, vlo_q};
          set_i      = 1'b1;
        end
      end
      ST_PUSH_H: begin
        bus_wr    = rdy;
        bus_addr  = stack_slot(sp_q, 2'd0);
        bus_wdata = pc_q[15:8];
      end
      ST_PUSH_L: begin
        bus_wr    = rdy;
        bus_addr  = stack_slot(sp_q, 2'd1);
        bus_wdata = pc_q[7:0];
      end
      ST_PUSH_P: begin
        bus_wr    = rdy;
        bus_addr  = stack_slot(sp_q, 2'd2);
        bus_wdata = framed_status(p_q, src_q == SRC_BRK);
      end
      ST_VEC_L: begin
        bus_rd     = 1'b1;
        bus_addr   = vec_q;
        vec_pull_n = 1'b0;
      end
      ST_VEC_H: begin
        bus_rd     = 1'b1;
        bus_addr   = vec_q + 16'd1;
        vec_pull_n = 1'b0;
        pc_load    = rdy;
        pc_value   = {rd_data, vlo_q};
        sp_load    = rdy;
        sp_value   = stack_slot(sp_q, 2'd3) [7:0];
        set_i      = rdy;
      end
      default: ;
    endcase
  end

  // R9: the vector-pull strobe only accompanies a read in the vector area
  a_r9_pull_on_vector: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_pull_n |-> (bus_rd && (bus_addr[15:3] == 13'h1FFF)));

  // R6: every write lands in the stack page
  a_r6_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_addr[15:8] == STACK_PAGE));

  // R6: a program-counter load ends the sequence
  a_r6_load_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  // R10: a stalled interrupt cycle keeps its address and state
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (in_irq_seq && !rdy) |=> ($stable(bus_addr) && $stable(state)));

  // R2: reset counter never runs past the sequence length
  a_r2_reset_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |-> (rcnt <= RST_LAST));

  // R10: no write strobe while ready is low
  a_r10_no_write_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> !bus_wr);

endmodule

// File: rtl/irq_entry_sequencer.sv
module irq_entry_sequencer
  import irq_seq_pkg::*;
#(
  parameter int RST_CYCLES = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_n,
  input  logic        irq_n,
  input  logic        brk_req,
  input  logic        i_flag,
  input  logic        insn_done,
  input  logic        rdy,
  input  logic [15:0] pc_in,
  input  logic [7:0]  status_in,
  input  logic [7:0]  sp_in,
  input  logic [7:0]  rd_data,
  output logic        busy,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  output logic        vec_pull_n,
  output logic        pc_load,
  output logic [15:0] pc_value,
  output logic        sp_load,
  output logic [7:0]  sp_value,
  output logic        set_i
);

  logic nmi_pend;
  logic nmi_fell;
  logic take_nmi;
  logic boundary_ok;
  src_t grant;

  irq_seq_nmi_latch u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_n    (nmi_n),
    .take_nmi (take_nmi),
    .nmi_pend (nmi_pend),
    .nmi_fell (nmi_fell)
  );

  irq_seq_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_ok (boundary_ok),
    .nmi_pend    (nmi_pend),
    .irq_n       (irq_n),
    .i_flag      (i_flag),
    .brk_req     (brk_req),
    .grant       (grant),
    .take_nmi    (take_nmi)
  );

  irq_seq_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rdy         (rdy),
    .insn_done   (insn_done),
    .grant       (grant),
    .pc_in       (pc_in),
    .status_in   (status_in),
    .sp_in       (sp_in),
    .rd_data     (rd_data),
    .boundary_ok (boundary_ok),
    .busy        (busy),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .vec_pull_n  (vec_pull_n),
    .pc_load     (pc_load),
    .pc_value    (pc_value),
    .sp_load     (sp_load),
    .sp_value    (sp_value),
    .set_i       (set_i)
  );

  // R3: an accepted non-maskable request consumes a pending edge
  a_r3_take_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> nmi_pend);

endmodule

// File: tb/irq_entry_sequencer_tb_top.sv
module irq_entry_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_n = 1'b1;
  logic        irq_n = 1'b1;
  logic        brk_req = 1'b0;
  logic        i_flag = 1'b1;
  logic        insn_done = 1'b0;
  logic        rdy = 1'b1;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  status_in = 8'h00;
  logic [7:0]  sp_in = 8'hFF;
  logic [7:0]  rd_data;
  logic        busy, bus_rd, bus_wr, vec_pull_n, pc_load, sp_load, set_i;
  logic [15:0] bus_addr, pc_value;
  logic [7:0]  bus_wdata, sp_value;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  localparam logic [54:0] STALL_MASK = ~((55'd1 << 52) | (55'd1 << 26) | (55'd1 << 9) | 55'd1);

  always #2 clk = ~clk;  // 250 MHz

  irq_entry_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n), .brk_req(brk_req),
    .i_flag(i_flag), .insn_done(insn_done), .rdy(rdy), .pc_in(pc_in),
    .status_in(status_in), .sp_in(sp_in), .rd_data(rd_data), .busy(busy),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .vec_pull_n(vec_pull_n), .pc_load(pc_load), .pc_value(pc_value),
    .sp_load(sp_load), .sp_value(sp_value), .set_i(set_i)
  );

  // memory model: every byte is a fixed arithmetic function of its address
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[2:0], 5'h15};
  endfunction
  assign rd_data = mem_byte(bus_addr);

  function automatic logic [54:0] mk(input logic b, input logic rd, input logic wr,
      input logic vp, input logic [15:0] ad, input logic [7:0] wd, input logic pl,
      input logic [15:0] pv, input logic sl, input logic [7:0] sv, input logic si);
    return {b, rd, wr, vp, ad, wd, pl, pv, sl, sv, si};
  endfunction

  function automatic logic [54:0] obs();
    return {busy, bus_rd, bus_wr, vec_pull_n, bus_addr, bus_wdata, pc_load,
            pc_value, sp_load, sp_value, set_i};
  endfunction

  localparam logic [54:0] IDLE_V = {3'b000, 1'b1, 51'd0};

  task automatic check(input string tag, input logic [54:0] act, input logic [54:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic boundary();
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    brk_req   = 1'b0;
  endtask

  // src: 1 non-maskable, 2 maskable, 3 break. Called at the negedge of push cycle 1.
  task automatic expect_entry(input string tag, input int src, input logic [15:0] pc,
      input logic [7:0] p, input logic [7:0] sp, input int stall_k, input int stall_len,
      input int nmi_drop_k);
    logic [15:0] vec;
    logic [7:0]  st;
    logic [54:0] e;
    vec = (src == 1) ? 16'hFFFA : 16'hFFFE;
    st  = {p[7:6], 1'b1, (src == 3), p[3:0]};
    for (int k = 1; k <= 5; k++) begin
      case (k)
        1: e = mk(1, 0, 1, 1, {8'h01, sp}, pc[15:8], 0, 0, 0, 0, 0);
        2: e = mk(1, 0, 1, 1, {8'h01, sp - 8'd1}, pc[7:0], 0, 0, 0, 0, 0);
        3: e = mk(1, 0, 1, 1, {8'h01, sp - 8'd2}, st, 0, 0, 0, 0, 0);
        4: e = mk(1, 1, 0, 0, vec, 8'h00, 0, 0, 0, 0, 0);
        default: e = mk(1, 1, 0, 0, vec + 16'd1, 8'h00, 1,
                        {mem_byte(vec + 16'd1), mem_byte(vec)}, 1, sp - 8'd3, 1);
      endcase
      check($sformatf("%s R6/R7/R9 cycle %0d", tag, k), obs(), e);
      if (k == nmi_drop_k) nmi_n = 1'b0;
      if (k == stall_k) begin
        rdy = 1'b0;
        for (int s = 0; s < stall_len; s++) begin
          @(negedge clk);
          check($sformatf("%s R10 stalled cycle %0d", tag, k), obs(), e & STALL_MASK);
        end
        rdy = 1'b1;
      end
      @(negedge clk);
    end
    check({tag, " R6 idle after load"}, obs(), IDLE_V);
  endtask

  task automatic reset_seq(input string tag);
    rst_n = 1'b0;
    rdy   = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rdy = ~rdy;
      check({tag, " R1 hold"}, obs(), mk(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    end
    rst_n = 1'b1;
    rdy   = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k <= 5)
        check($sformatf("%s R2 cycle %0d", tag, k), obs(), mk(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
      else if (k == 6)
        check({tag, " R2/R9 vector low"}, obs(), mk(1, 1, 0, 0, 16'hFFFC, 0, 0, 0, 0, 0, 0));
      else if (k == 7)
        check({tag, " R2 vector high"}, obs(), mk(1, 1, 0, 0, 16'hFFFD, 0, 1,
              {mem_byte(16'hFFFD), mem_byte(16'hFFFC)}, 0, 0, 1));
      else
        check({tag, " R2 idle"}, obs(), IDLE_V);
    end
    rdy = 1'b1;
  endtask

  task automatic nmi_pulse();
    nmi_n = 1'b0;
    @(negedge clk);
    nmi_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    reset_seq("por");

    // R8/R5/R3 sweep over all request combinations
    for (int c = 0; c < 16; c++) begin
      bit nm, iq, ifl, bk;
      int src;
      nm  = c[0];
      iq  = c[1];
      ifl = c[2];
      bk  = c[3];
      src = nm ? 1 : ((iq && !ifl) ? 2 : (bk ? 3 : 0));
      if (nm) nmi_pulse();
      irq_n     = ~iq;
      i_flag    = ifl;
      brk_req   = bk;
      pc_in     = 16'h1234 ^ (16'(c) * 16'h1111);
      status_in = 8'(c) * 8'h1D ^ 8'hC3;
      sp_in     = 8'hF0 - 8'(c * 5);
      boundary();
      if (src == 0) begin
        check($sformatf("sweep %0d R5 masked/no request", c), obs(), IDLE_V);
        @(negedge clk);
        check($sformatf("sweep %0d R5 still idle", c), obs(), IDLE_V);
      end else begin
        expect_entry($sformatf("sweep %0d R8", c), src, pc_in, status_in, sp_in, 0, 0, 0);
      end
      irq_n = 1'b1;
      @(negedge clk);
    end

    // R4: held low gives one entry only
    i_flag = 1'b1;
    nmi_n  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pc_in = 16'hBEEF; status_in = 8'h81; sp_in = 8'h40;
    boundary();
    expect_entry("R4 first", 1, 16'hBEEF, 8'h81, 8'h40, 0, 0, 0);
    boundary();
    check("R4 held low no re-entry", obs(), IDLE_V);
    nmi_n = 1'b1;
    @(negedge clk);
    nmi_pulse();
    boundary();
    expect_entry("R4 new edge", 1, 16'hBEEF, 8'h81, 8'h40, 0, 0, 0);

    // R3: edge during a maskable entry is served afterwards
    irq_n = 1'b0; i_flag = 1'b0;
    pc_in = 16'h0F00; status_in = 8'h02; sp_in = 8'h90;
    boundary();
    expect_entry("R3 carrier irq", 2, 16'h0F00, 8'h02, 8'h90, 0, 0, 2);
    irq_n = 1'b1; nmi_n = 1'b1; i_flag = 1'b1;
    boundary();
    expect_entry("R3 latched nmi", 1, 16'h0F00, 8'h02, 8'h90, 0, 0, 0);

    // R10: boundary with ready low is not accepted, then stalls inside the sequence
    irq_n = 1'b0; i_flag = 1'b0; rdy = 1'b0;
    boundary();
    check("R10 boundary while not ready", obs(), IDLE_V);
    rdy = 1'b1;
    pc_in = 16'hA55A; status_in = 8'h7F; sp_in = 8'h22;
    for (int k = 1; k <= 5; k++) begin
      boundary();
      expect_entry($sformatf("R10 stall at %0d", k), 2, 16'hA55A, 8'h7F, 8'h22, k, 2, 0);
    end
    irq_n = 1'b1;

    // R11: stack wrap inside page 1
    brk_req = 1'b1; pc_in = 16'h3000; status_in = 8'h10; sp_in = 8'h01;
    boundary();
    expect_entry("R11 wrap break", 3, 16'h3000, 8'h10, 8'h01, 0, 0, 0);

    // R1: reset mid-sequence aborts it, then full reset sequence
    irq_n = 1'b0; i_flag = 1'b0;
    boundary();
    @(negedge clk);
    irq_n = 1'b1;
    reset_seq("mid-sequence");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule